// File: doc/BRIEF.md
# SPI Controller Channel with Receive-Only Operation

This block is one channel of an SPI controller. It holds one word waiting to be sent, one word that has been received, and the shift register that moves bits over the wire. A two-bit mode input picks how transfers are started. In full-duplex mode a transfer starts whenever a transmit word is waiting. In transmit-only mode it works the same way, but received bits are thrown away. In receive-only mode a transfer starts only when the receive holding register is empty.

In receive-only mode the transmit word is never used up. Software writes one dummy word, and that word is shifted out again on every transfer. The channel then keeps pulling in words as fast as software reads them. The transmit-empty, transmit-underflow and receive-overflow flags stay quiet in this mode.

The wire protocol is SPI mode 0, most significant bit first. SCLK runs at the system clock divided by an even parameter. Chip select is held low for exactly one word.

Top module: `spi_chan_ctl`

## Requirements
- R1: The mode input is decoded as follows: 2'b00 is full-duplex, 2'b01 is receive-only, 2'b10 is transmit-only, and 2'b11 behaves exactly as full-duplex.
- R2: In receive-only mode a transfer starts only while RX-full is low; whether a TX word is waiting plays no part. One TX write then serves any number of transfers, and each transfer shifts out that same word.
- R3: In receive-only mode, after the TX holding register has been written, tx_empty and tx_underflow stay low.
- R4: In receive-only mode rx_overflow never rises.
- R5: When a word completes in full-duplex or receive-only mode, it is copied to rx_rdata and rx_full goes high. In transmit-only mode received words are discarded and rx_full is not changed.
- R6: eot is 1 while the shifter is idle and 0 while a word is shifting. cs_n is low for exactly the time eot is 0.
- R7: A one-cycle rx_rd pulse clears rx_full at the next clock edge. In receive-only mode with the dummy word present, cs_n falls at the second clock edge after the pulse.
- R8: In full-duplex and transmit-only modes a transfer starts only while a TX word is waiting. Loading the shifter empties the holding register, so tx_empty goes high the cycle the transfer begins.
- R9: If a word completes while rx_full is still high in full-duplex mode, rx_overflow goes high. It stays high until the next rx_rd.
- R10: tx_underflow goes high when a word completes while the TX holding register is empty. A TX write clears it.
- R11: The SPI timing is mode 0, MSB first. SCLK idles low and changes every CLK_DIV/2 clocks. MOSI changes on the falling edge and MISO is sampled on the rising edge. One word keeps cs_n low for WORD_W*CLK_DIV clocks.
- R12: After reset, tx_empty=1, eot=1, cs_n=1 and sclk=0, while rx_full, rx_overflow, tx_underflow and rx_rdata are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Transfer mode select |
| tx_wr | input | 1 | Write strobe for the TX holding register |
| tx_wdata | input | WORD_W | Data written to the TX holding register |
| rx_rd | input | 1 | Read strobe; clears rx_full and rx_overflow |
| rx_rdata | output | WORD_W | RX holding register contents |
| tx_empty | output | 1 | No TX word waiting |
| tx_underflow | output | 1 | A word completed with the TX holding register empty |
| rx_full | output | 1 | An unread received word is held |
| rx_overflow | output | 1 | A received word replaced an unread one |
| eot | output | 1 | Shifter idle |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
Several properties are checked on every cycle:
- no completion lands on a full RX register in receive-only mode;
- in that mode the TX word, once present, is never consumed;
- every start pulls cs_n low and clears eot;
- SCLK is low whenever chip select is high;
- an empty TX register blocks any start in the other modes.

Other behaviour only the directed scenarios can show:
- the actual bit order on MOSI and MISO;
- the exact word length in clocks;
- the two-cycle restart after a read in receive-only mode;
- that the same dummy word goes out on every transfer;
- that transmit-only mode discards received words;
- how the overflow and underflow flags set and clear.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
   typedef enum logic [1:0] {
      XFER_DUPLEX  = 2'b00,
      XFER_RX_ONLY = 2'b01,
      XFER_TX_ONLY = 2'b10,
      XFER_RSVD    = 2'b11
   } xfer_mode_e;
endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;
   logic          sclk_q;
   logic          term;

   assign term      = (cnt == CW'(HALF - 1));
   assign rise_tick = run && term && !sclk_q;
   assign fall_tick = run && term && sclk_q;
   assign sclk      = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         sclk_q <= 1'b0;
      end else if (!run) begin
         cnt    <= '0;
         sclk_q <= 1'b0;
      end else if (term) begin
         cnt    <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R11
   sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sclk_q);
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
   parameter int WORD_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] din,
   input  logic              rise,
   input  logic              fall,
   input  logic              miso,
   output logic              busy,
   output logic              mosi,
   output logic              done,
   output logic [WORD_W-1:0] dout
);
   localparam int BW = $clog2(WORD_W);

   logic [WORD_W-1:0] sh_tx, sh_rx, tx_next, rx_next;
   logic [BW-1:0]     bit_cnt;
   logic              last;

   generate
      if (MSB_FIRST) begin : g_msb
         assign mosi    = sh_tx[WORD_W-1];
         assign tx_next = {sh_tx[WORD_W-2:0], 1'b0};
         assign rx_next = {sh_rx[WORD_W-2:0], miso};
      end else begin : g_lsb
         assign mosi    = sh_tx[0];
         assign tx_next = {1'b0, sh_tx[WORD_W-1:1]};
         assign rx_next = {miso, sh_rx[WORD_W-1:1]};
      end
   endgenerate

   assign last = (bit_cnt == BW'(WORD_W - 1));
   assign done = fall && last;
   assign dout = sh_rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sh_tx   <= '0;
         sh_rx   <= '0;
         bit_cnt <= '0;
      end else if (!busy) begin
         if (start) begin
            busy    <= 1'b1;
            sh_tx   <= din;
            bit_cnt <= '0;
         end
      end else begin
         if (rise) sh_rx <= rx_next;
         if (fall) begin
            if (last) begin
               busy <= 1'b0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
               sh_tx   <= tx_next;
            end
         end
      end
   end

   // R6
   word_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

// File: rtl/spi_chan_ctl.sv
module spi_chan_ctl
   import spi_chan_pkg::*;
#(
   parameter int WORD_W    = 8,
   parameter int CLK_DIV   = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              tx_wr,
   input  logic [WORD_W-1:0] tx_wdata,
   input  logic              rx_rd,
   output logic [WORD_W-1:0] rx_rdata,
   output logic              tx_empty,
   output logic              tx_underflow,
   output logic              rx_full,
   output logic              rx_overflow,
   output logic              eot,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n
);
   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (WORD_W < 2) begin : g_bad_w
         $error("WORD_W must be at least 2");
      end
   endgenerate

   xfer_mode_e        md;
   logic              rx_only, tx_only;
   logic              busy, start, done, rise, fall;
   logic [WORD_W-1:0] tx_hold, rx_hold, sh_out;
   logic              tx_valid;

   assign md      = xfer_mode_e'(mode);
   assign rx_only = (md == XFER_RX_ONLY);
   assign tx_only = (md == XFER_TX_ONLY);
   assign start   = !busy && (rx_only ? !rx_full : tx_valid);

   spi_sclk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(busy),
      .sclk(sclk), .rise_tick(rise), .fall_tick(fall)
   );

   spi_word_shifter #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .din(tx_hold),
      .rise(rise), .fall(fall), .miso(miso),
      .busy(busy), .mosi(mosi), .done(done), .dout(sh_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_hold      <= '0;
         tx_valid     <= 1'b0;
         tx_underflow <= 1'b0;
      end else begin
         if (tx_wr) begin
            tx_hold      <= tx_wdata;
            tx_valid     <= 1'b1;
            tx_underflow <= 1'b0;
         end else begin
            if (start && !rx_only) tx_valid <= 1'b0;
            if (done && !tx_valid) tx_underflow <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_hold     <= '0;
         rx_full     <= 1'b0;
         rx_overflow <= 1'b0;
      end else if (done && !tx_only) begin
         rx_hold <= sh_out;
         rx_full <= 1'b1;
         if (rx_full && !rx_rd) rx_overflow <= 1'b1;
         else if (rx_rd)        rx_overflow <= 1'b0;
      end else if (rx_rd) begin
         rx_full     <= 1'b0;
         rx_overflow <= 1'b0;
      end
   end

   assign rx_rdata = rx_hold;
   assign tx_empty = !tx_valid;
   assign eot      = !busy;
   assign cs_n     = !busy;

   // R4
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_only && done) |-> !rx_full);
   // R3
   tx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_only && !tx_empty) |=> !tx_empty);
   // R3
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_only && !tx_empty && !tx_underflow) |=> !tx_underflow);
   // R6
   cs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!cs_n && !eot));
   // R5
   rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !tx_only) |=> rx_full);
   // R11
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   // R8
   fd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !rx_only && tx_empty) |=> eot);
endmodule

// File: tb/tb_spi_chan_ctl.sv
module tb_spi_chan_ctl;
   localparam int W   = 8;
   localparam int DIV = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic         tx_wr = 1'b0;
   logic [W-1:0] tx_wdata = '0;
   logic         rx_rd = 1'b0;
   logic [W-1:0] rx_rdata;
   logic         tx_empty, tx_underflow, rx_full, rx_overflow, eot;
   logic         sclk, mosi, cs_n;
   logic         miso = 1'b0;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   logic [W-1:0] slv_data = '0;
   logic [W-1:0] slv_bits = '0;
   logic [W-1:0] mosi_cap = '0;
   bit           mon_on = 1'b0;
   int           mon_hits = 0;

   always #4 clk = ~clk;

   spi_chan_ctl #(.WORD_W(W), .CLK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .rx_rd(rx_rd), .rx_rdata(rx_rdata), .tx_empty(tx_empty),
      .tx_underflow(tx_underflow), .rx_full(rx_full), .rx_overflow(rx_overflow),
      .eot(eot), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   // peripheral model: mode 0, MSB first
   always @(negedge cs_n) begin
      slv_bits = slv_data;
      miso     = slv_bits[W-1];
      mosi_cap = '0;
   end
   always @(negedge sclk) if (!cs_n) begin
      slv_bits = {slv_bits[W-2:0], 1'b0};
      miso     = slv_bits[W-1];
   end
   always @(posedge sclk) mosi_cap = {mosi_cap[W-2:0], mosi};

   always @(negedge clk) if (mon_on && (tx_empty || tx_underflow || rx_overflow))
      mon_hits++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_idle(output int busy_cycles);
      busy_cycles = 0;
      while (eot == 1'b0 && busy_cycles < 2000) begin
         busy_cycles++;
         @(negedge clk);
      end
   endtask

   task automatic write_tx(input logic [W-1:0] d);
      tx_wr = 1'b1; tx_wdata = d;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic read_rx;
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic t_reset;
      chk("R12 tx_empty", tx_empty, 1);
      chk("R12 eot", eot, 1);
      chk("R12 cs_n", cs_n, 1);
      chk("R12 sclk", sclk, 0);
      chk("R12 flags", {rx_full, rx_overflow, tx_underflow}, 0);
      chk("R12 rx_rdata", rx_rdata, 0);
   endtask

   task automatic t_idle_gate;
      mode = 2'b00;
      repeat (30) @(negedge clk);
      chk("R8 no start with empty TX", {eot, cs_n}, 2'b11);
   endtask

   task automatic t_tx_only;
      int n;
      mode = 2'b10; slv_data = 8'h55;
      write_tx(8'h81);
      @(negedge clk);
      chk("R8 tx_empty after load", tx_empty, 1);
      chk("R6 eot low while shifting", {eot, cs_n}, 2'b00);
      wait_idle(n);
      chk("R11 word length", n, W * DIV);
      chk("R11 mosi bits", mosi_cap, 8'h81);
      chk("R5 tx-only discards rx", rx_full, 0);
      chk("R1 tx-only rdata untouched", rx_rdata, 0);
      chk("R10 underflow set", tx_underflow, 1);
   endtask

   task automatic t_mode_rsvd;
      int n;
      mode = 2'b11; slv_data = 8'hF0;
      write_tx(8'h0F);
      @(negedge clk);
      chk("R1 mode 11 loads like duplex", tx_empty, 1);
      wait_idle(n);
      chk("R1 mode 11 receives", {rx_full, rx_rdata}, {1'b1, 8'hF0});
      read_rx;
      chk("R7 read clears rx_full", rx_full, 0);
   endtask

   task automatic t_duplex;
      int n;
      mode = 2'b00; slv_data = 8'h3C;
      write_tx(8'hA5);
      chk("R10 write clears underflow", tx_underflow, 0);
      @(negedge clk);
      wait_idle(n);
      chk("R5 duplex rx data", {rx_full, rx_rdata}, {1'b1, 8'h3C});
      chk("R11 duplex mosi", mosi_cap, 8'hA5);
      chk("R9 no overflow yet", rx_overflow, 0);
      slv_data = 8'hC3;
      write_tx(8'h5A);
      @(negedge clk);
      wait_idle(n);
      chk("R9 overflow on unread", rx_overflow, 1);
      chk("R9 newest data held", rx_rdata, 8'hC3);
      read_rx;
      chk("R9 read clears overflow", {rx_overflow, rx_full}, 0);
      slv_data = 8'h99;
      write_tx(8'h66);
      @(negedge clk);
      wait_idle(n);
      chk("R5 third word", {rx_full, rx_rdata}, {1'b1, 8'h99});
   endtask

   task automatic t_rx_only;
      int n;
      mode = 2'b01;
      write_tx(8'hFF);
      chk("R2 no start while rx_full", {eot, cs_n}, 2'b11);
      chk("R3 dummy present", {tx_empty, tx_underflow}, 0);
      mon_on = 1'b1;
      for (int k = 0; k < 5; k++) begin
         slv_data = 8'h21 + 8'(k * 8'h13);
         read_rx;
         chk("R7 rx_full cleared", {rx_full, cs_n}, 2'b01);
         @(negedge clk);
         chk("R7 restart two edges after read", cs_n, 0);
         wait_idle(n);
         chk("R2 rx-only data", {rx_full, rx_rdata}, {1'b1, slv_data});
         chk("R2 same dummy shifted", mosi_cap, 8'hFF);
         repeat (40) @(negedge clk);
         chk("R2 held off while rx_full", {eot, cs_n}, 2'b11);
      end
      mon_on = 1'b0;
      chk("R3 R4 flags quiet in rx-only", mon_hits, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_idle_gate;
      t_tx_only;
      t_mode_rsvd;
      t_duplex;
      t_rx_only;
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule